// File: doc/BRIEF.md
# Three-Hit Sticky Recognizer

This block watches a single serial input and raises a flag once that input has been seen high on three clock edges since the last reset. The three high samples may be spread out with any number of low samples between them. Low samples neither advance nor clear the progress made so far. Once the flag is up it stays up, whatever the input does, until reset is applied again.

Progress is held in a four-state machine: no hits, one hit, two hits, and done. The done state absorbs all further input. The flag comes from its own register, which is loaded on the same edge as the state. It therefore rises directly after the edge that samples the third high input, and no combinational path runs from the input to the flag. Reset is active low. It clears the block at once, without waiting for a clock edge, but its release passes through a short synchronizer. For that reason the first few edges after release do not count.

Top module: `occ3_recognizer`

## Requirements
- R1: While `rst_n` is low, `flag_o` is 0. Driving `rst_n` low clears `flag_o` at once, without a clock edge.
- R2: The release of reset is synchronized through SYNC_STAGES flip-flops (default 2). With the default, `sample_i` is ignored at the first two rising edges after `rst_n` goes high, and counting begins at the third edge.
- R3: `flag_o` goes to 1 directly after the rising edge that samples `sample_i` high for the third counted time, and is 1 before the following edge.
- R4: While fewer than three high samples have been counted, `flag_o` is 0.
- R5: The counted high samples need not be consecutive. An edge with `sample_i` low leaves the progress unchanged.
- R6: Once `flag_o` is 1, it stays 1 for any values of `sample_i` until `rst_n` is driven low.
- R7: After any reset, three new high samples are needed before `flag_o` rises. Progress made before the reset is lost.
- R8: `flag_o` changes only at a rising clock edge or on reset. A change of `sample_i` between edges has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| sample_i | input | 1 | Serial input sampled on each rising edge |
| flag_o | output | 1 | Sticky flag, 1 after three counted high samples |

## Verification
The hardest situation to reach from the ports is the edge of the release window. There, high samples arrive while the internal reset is still held, and they must not count. The stimulus holds `sample_i` high through the release and across the edges that follow. It then checks that the flag rises only on the third edge after the synchronizer opens, and not after three high samples in total. A second hard case is a reset that arrives mid-cycle in the done state. The bench drives it between edges, checks the flag at once, and then checks that two new hits are not enough to raise it.

// File: rtl/occ3_pkg.sv
package occ3_pkg;
  typedef enum logic [1:0] {
    ST_ZERO = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2,
    ST_DONE = 2'd3
  } occ3_state_e;

  localparam int STATE_W = $bits(occ3_state_e);
endpackage

// File: rtl/occ3_rst_sync.sv
module occ3_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= (sr_q << 1) | STAGES'(1);
    end
  end

  assign rst_o = sr_q[STAGES-1];
endmodule

// File: rtl/occ3_next.sv
module occ3_next
  import occ3_pkg::*;
(
  input  logic [STATE_W-1:0] state_q,
  input  logic               sample_i,
  output logic [STATE_W-1:0] state_d,
  output logic               load_en,
  output logic               flag_d
);
  occ3_state_e cur;
  occ3_state_e nxt;

  assign cur = occ3_state_e'(state_q);

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_ZERO: nxt = ST_ONE;
      ST_ONE:  nxt = ST_TWO;
      ST_TWO:  nxt = ST_DONE;
      ST_DONE: nxt = ST_DONE;
      default: nxt = ST_ZERO;
    endcase
  end

  // Advance only on a high sample, and never out of the absorbing state.
  assign load_en = sample_i && (cur != ST_DONE);
  assign state_d = STATE_W'(nxt);
  assign flag_d  = (nxt == ST_DONE);
endmodule

// File: rtl/occ3_en_reg.sv
module occ3_en_reg #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/occ3_recognizer.sv
module occ3_recognizer
  import occ3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  output logic flag_o
);
  logic               rst_int;
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic               load_en;
  logic               flag_d;

  occ3_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_o (rst_int)
  );

  occ3_next u_next (
    .state_q  (state_q),
    .sample_i (sample_i),
    .state_d  (state_d),
    .load_en  (load_en),
    .flag_d   (flag_d)
  );

  occ3_en_reg #(.W(STATE_W), .RST_VAL(STATE_W'(ST_ZERO))) u_state (
    .clk   (clk),
    .rst_n (rst_int),
    .en    (load_en),
    .d     (state_d),
    .q     (state_q)
  );

  occ3_en_reg #(.W(1), .RST_VAL(1'b0)) u_flag (
    .clk   (clk),
    .rst_n (rst_int),
    .en    (load_en),
    .d     (flag_d),
    .q     (flag_o)
  );
endmodule

// File: rtl/occ3_recognizer_chk.sv
module occ3_recognizer_chk
  import occ3_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rst_int,
  input logic               x,
  input logic               y,
  input logic [STATE_W-1:0] state
);
  // Independent tally of high samples taken while the core is out of reset.
  logic [1:0] hits_q;

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      hits_q <= 2'd0;
    end else if (x && hits_q != 2'd3) begin
      hits_q <= hits_q + 2'd1;
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk) !rst_n |-> !y);

  p_third_hit_r3: assert property (@(posedge clk) disable iff (!rst_int)
    (hits_q == 2'd3) |-> y);

  p_rise_on_high_r3: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(y) |-> $past(x));

  p_early_low_r4: assert property (@(posedge clk) disable iff (!rst_int)
    (hits_q != 2'd3) |-> !y);

  p_low_holds_r5: assert property (@(posedge clk) disable iff (!rst_int)
    (!x && state != STATE_W'(ST_DONE)) |=> $stable(state));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    y |=> y);
endmodule

bind occ3_recognizer occ3_recognizer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_int (rst_int),
  .x       (sample_i),
  .y       (flag_o),
  .state   (state_q)
);

// File: tb/occ3_recognizer_test.sv
module occ3_recognizer_test;
  logic clk;
  logic rst_n;
  logic x;
  logic y;
  int   n_tests;
  int   n_fail;
  bit   done;

  occ3_recognizer uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (x),
    .flag_o   (y)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Hold reset, then release it at a falling edge and let the two
  // synchronizer edges pass with x held at xv.
  task automatic do_reset(input logic xv);
    @(negedge clk);
    rst_n = 1'b0;
    x = xv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // One cycle: drive x, let one rising edge sample it, return at the falling edge.
  task automatic cyc(input logic xv);
    x = xv;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0;
    x = 1'b1;
    repeat (3) @(negedge clk);
    chk(y, 1'b0, "R1", "flag during reset");
    rst_n = 1'b1;
    x = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(y, 1'b0, "R1", "flag after release");
  endtask

  task automatic t_consecutive;
    do_reset(1'b0);
    cyc(1'b1);
    cyc(1'b1);
    chk(y, 1'b0, "R4", "two consecutive hits");
    cyc(1'b1);
    chk(y, 1'b1, "R3", "third consecutive hit");
  endtask

  task automatic t_spread;
    do_reset(1'b0);
    cyc(1'b1);
    cyc(1'b0);
    cyc(1'b0);
    cyc(1'b1);
    chk(y, 1'b0, "R5", "two spread hits");
    for (int i = 0; i < 6; i++) cyc(1'b0);
    chk(y, 1'b0, "R5", "low run keeps progress below three");
    cyc(1'b1);
    chk(y, 1'b1, "R5", "third spread hit after low run");
  endtask

  task automatic t_all_low;
    do_reset(1'b0);
    for (int i = 0; i < 20; i++) cyc(1'b0);
    chk(y, 1'b0, "R4", "no hits over many cycles");
  endtask

  task automatic t_sticky;
    bit stayed;
    do_reset(1'b0);
    repeat (3) cyc(1'b1);
    stayed = 1'b1;
    for (int i = 0; i < 12; i++) begin
      cyc(logic'(i % 3 == 0));
      if (y !== 1'b1) stayed = 1'b0;
    end
    chk(stayed, 1'b1, "R6", "flag held across mixed input");
  endtask

  task automatic t_release_window;
    do_reset(1'b1);
    chk(y, 1'b0, "R2", "window edges not counted");
    cyc(1'b1);
    cyc(1'b1);
    chk(y, 1'b0, "R2", "two hits after window");
    cyc(1'b1);
    chk(y, 1'b1, "R2", "third hit after window");
  endtask

  task automatic t_mid_cycle;
    do_reset(1'b0);
    cyc(1'b1);
    cyc(1'b1);
    x = 1'b1;
    #2;
    chk(y, 1'b0, "R8", "no change between edges");
    @(negedge clk);
    chk(y, 1'b1, "R8", "change after edge");
    x = 1'b0;
    #1;
    chk(y, 1'b1, "R8", "x drop between edges");
  endtask

  task automatic t_async_reset;
    do_reset(1'b0);
    repeat (3) cyc(1'b1);
    chk(y, 1'b1, "R7", "flag set before reset");
    #1;
    rst_n = 1'b0;
    #1;
    chk(y, 1'b0, "R1", "immediate clear without edge");
    x = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cyc(1'b1);
    cyc(1'b1);
    chk(y, 1'b0, "R7", "old progress discarded");
    cyc(1'b1);
    chk(y, 1'b1, "R7", "three fresh hits");
  endtask

  task automatic t_partial_reset;
    do_reset(1'b0);
    cyc(1'b1);
    cyc(1'b1);
    do_reset(1'b0);
    cyc(1'b1);
    chk(y, 1'b0, "R7", "partial progress cleared");
    cyc(1'b1);
    cyc(1'b1);
    chk(y, 1'b1, "R7", "fresh count completes");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    x       = 1'b0;
    t_reset_state();
    t_consecutive();
    t_spread();
    t_all_low();
    t_sticky();
    t_release_window();
    t_mid_cycle();
    t_async_reset();
    t_partial_reset();
    finish_run();
  end
endmodule